// File: doc/BRIEF.md
# I2C Slave Control Port with Data-Waiting Request

This block is a byte-wide slave control port. It sits between an internal processor core and an external master on a two-wire I2C-style bus. The core talks to it through three registers. The first is an outbound byte that the master will read. The second is an inbound byte that the master has written. The third is a control register that holds the 7-bit slave address and an address-check enable.

When the core loads the outbound byte, the block pulls an active-low request output low, which tells the master that a byte is waiting. The master then addresses the slave for a read and clocks the byte out, MSB first. Once the ninth clock of that byte has completed, the request line goes high again. On a write, the slave takes in one byte, hands it to the core with a single-cycle strobe, and acknowledges it. If the core has not yet consumed the previous byte, the slave withholds the acknowledge so that the master retries.

The bus lines are brought into the system clock domain through a synchronizer chain, and start and stop conditions are detected on the synchronized levels. The slave only ever pulls SDA low, through an open-drain enable. Each transaction carries exactly one data byte.

Top module: `i2c_req_slave`

## Requirements
- R1: After reset, `req_n_o` is 1, `sda_pull_o` is 0 and `in_valid_o` is 0.
- R2: A pulse on `out_we_i` loads `out_data_i` into the outbound byte and drives `req_n_o` low by the next clock.
- R3: The address byte is 7 address bits, MSB first, followed by a direction bit (1 = read, 0 = write). With address checking on (`ctl_chk_i` = 1 when written), the slave pulls SDA low during the ninth clock of an address byte that matches the stored address.
- R4: With address checking on, a non-matching address gets no acknowledge. The slave then stays silent until the next start, and the core receives no strobe.
- R5: With address checking off, any address is acknowledged.
- R6: A byte written by the master appears on `in_data_o` together with an `in_valid_o` pulse that lasts exactly one cycle, and the slave acknowledges the byte on the ninth clock.
- R7: While the inbound byte has not been consumed (no `in_taken_i` pulse since its strobe), a further written byte gets no acknowledge, raises no strobe, and leaves `in_data_o` unchanged.
- R8: On a read, the outbound byte is loaded at the falling SCL edge that ends the address acknowledge. D7 is on SDA before the first data rising edge, and bits D7..D0 are valid while SCL is high. SDA changes only after SCL falling edges or at bus start and stop conditions.
- R9: `req_n_o` returns to 1 once the master's ninth clock of a read completes, whether the master sends ACK or NACK.
- R10: A stop condition releases SDA and returns the slave to idle, even in the middle of a transaction. A later transaction then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| req_n_o | output | 1 | Active-low request: outbound byte waiting |
| out_we_i | input | 1 | Core write strobe for the outbound byte |
| out_data_i | input | 8 | Outbound byte from the core |
| ctl_we_i | input | 1 | Core write strobe for the control register |
| ctl_addr_i | input | 7 | Slave address to store |
| ctl_chk_i | input | 1 | Address-check enable to store |
| in_data_o | output | 8 | Last byte received from the master |
| in_valid_o | output | 1 | One-cycle strobe for a new inbound byte |
| in_taken_i | input | 1 | Core marks the inbound byte consumed |

## Verification
A corrupted bit counter or a stuck sequencer state is visible at the ports within one byte time. It shows up as an acknowledge on the wrong clock, which the master reads as a NACK where an ACK is due, or as shifted read data. A wrong inbound-occupancy flag shows up as an acknowledged byte with a missing or duplicated `in_valid_o` strobe, or as a NACK where an ACK is expected, on the very next write transaction. A request flag that fails to clear shows as `req_n_o` still low a few clocks after the read's ninth clock.

// File: rtl/i2c_req_pkg.sv
package i2c_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_HOLD
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_req_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_lvl,
  input  logic              chk_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] out_byte,
  input  logic              in_full,
  output logic              sda_pull,
  output logic              wr_store,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_done
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_RD  = CNT_W'(BYTE_W - 1);

  slv_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_read;
  logic              addr_hit;

  assign addr_hit = !chk_en || (shreg[BYTE_W-1 -: ADDR_W] == own_addr);
  assign wr_byte  = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      is_read  <= 1'b0;
      sda_pull <= 1'b0;
      wr_store <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      wr_store <= 1'b0;
      rd_done  <= 1'b0;
      if (bus_stop) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (bus_start) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && cnt != FULL_CNT) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL_CNT) begin
              if (addr_hit) begin
                sda_pull <= 1'b1;
                is_read  <= shreg[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                shreg    <= out_byte;
                sda_pull <= ~out_byte[BYTE_W-1];
                state    <= ST_RD_DATA;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_WR_DATA;
              end
            end
          end
          ST_WR_DATA: begin
            if (scl_rise && cnt != FULL_CNT) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL_CNT) begin
              if (!in_full) begin
                sda_pull <= 1'b1;
                wr_store <= 1'b1;
                state    <= ST_WR_ACK;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_HOLD;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall) begin
              if (cnt == LAST_RD) begin
                sda_pull <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_pull <= ~shreg[BYTE_W-2];
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              rd_done <= 1'b1;
              state   <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> (!sda_pull && state == ST_IDLE)); // R10
  AST_SDA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> $past(scl_fall || bus_start || bus_stop)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!sda_pull && !wr_store)); // R10
endmodule

// File: rtl/i2c_req_slave.sv
module i2c_req_slave #(
  parameter int                BYTE_W      = 8,
  parameter int                ADDR_W      = 7,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR  = 7'h2A,
  parameter logic              RESET_CHK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              req_n_o,
  input  logic              out_we_i,
  input  logic [BYTE_W-1:0] out_data_i,
  input  logic              ctl_we_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic              ctl_chk_i,
  output logic [BYTE_W-1:0] in_data_o,
  output logic              in_valid_o,
  input  logic              in_taken_i
);
  logic scl_rise, scl_fall, bus_start, bus_stop, sda_lvl;
  logic wr_store, rd_done;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] out_reg;
  logic [ADDR_W-1:0] ctl_addr;
  logic              ctl_chk;
  logic              in_full;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_lvl(sda_lvl)
  );

  i2c_slave_engine #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_lvl(sda_lvl),
    .chk_en(ctl_chk), .own_addr(ctl_addr), .out_byte(out_reg),
    .in_full(in_full), .sda_pull(sda_pull_o),
    .wr_store(wr_store), .wr_byte(wr_byte), .rd_done(rd_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_reg    <= '0;
      ctl_addr   <= RESET_ADDR;
      ctl_chk    <= RESET_CHK;
      in_data_o  <= '0;
      in_valid_o <= 1'b0;
      in_full    <= 1'b0;
      req_n_o    <= 1'b1;
    end else begin
      in_valid_o <= wr_store;
      if (wr_store) in_data_o <= wr_byte;
      if (ctl_we_i) begin
        ctl_addr <= ctl_addr_i;
        ctl_chk  <= ctl_chk_i;
      end
      if (wr_store)        in_full <= 1'b1;
      else if (in_taken_i) in_full <= 1'b0;
      if (out_we_i) begin
        out_reg <= out_data_i;
        req_n_o <= 1'b0;
      end else if (rd_done) begin
        req_n_o <= 1'b1;
      end
    end
  end

  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_store |-> !in_full); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    in_valid_o |=> !in_valid_o); // R6
  AST_REQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(req_n_o) |-> $past(rd_done)); // R9
  AST_LOAD_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
    out_we_i |=> !req_n_o); // R2
endmodule

// File: tb/tb_i2c_req_slave.sv
module tb_i2c_req_slave;
  localparam int Q = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull_o, req_n_o, in_valid_o;
  logic out_we_i = 1'b0, ctl_we_i = 1'b0, ctl_chk_i = 1'b1, in_taken_i = 1'b0;
  logic [7:0] out_data_i = '0, in_data_o;
  logic [6:0] ctl_addr_i = '0;
  wire sda_line = m_sda & ~sda_pull_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #10 clk = ~clk;

  i2c_req_slave dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .req_n_o(req_n_o),
    .out_we_i(out_we_i), .out_data_i(out_data_i),
    .ctl_we_i(ctl_we_i), .ctl_addr_i(ctl_addr_i), .ctl_chk_i(ctl_chk_i),
    .in_data_o(in_data_o), .in_valid_o(in_valid_o), .in_taken_i(in_taken_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (in_valid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected strobe", in_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(in_data_o == e, "R6 inbound byte", in_data_o, e);
        end
        chk(!prev_valid, "R6 strobe width", prev_valid, 0);
      end
      prev_valid <= in_valid_o;
    end
  end

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hc(Q); m_scl = 1'b1; hc(Q); m_sda = 1'b0; hc(Q); m_scl = 1'b0; hc(2);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; m_sda = 1'b0; hc(Q); m_scl = 1'b1; hc(Q); m_sda = 1'b1; hc(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; hc(Q); m_scl = 1'b1; hc(Q); m_scl = 1'b0; hc(2);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    m_sda = 1'b1; hc(Q); m_scl = 1'b1; hc(Q/2); ack = sda_line; hc(Q/2); m_scl = 1'b0; hc(2);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] d,
                           input logic ea, input logic ed, input string req);
    logic ak, dk;
    if (!ea && !ed) exp_q.push_back(d);
    bus_start();
    put_byte({a, 1'b0}, ak);
    chk(ak == ea, {req, " address ack"}, ak, ea);
    put_byte(d, dk);
    chk(dk == ed, {req, " data ack"}, dk, ed);
    bus_stop();
    hc(4);
  endtask

  task automatic read_txn(input logic [6:0] a, input logic [7:0] e, input logic mack);
    logic ak;
    logic [7:0] got;
    bus_start();
    put_byte({a, 1'b1}, ak);
    chk(ak == 1'b0, "R8 read address ack", ak, 0);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hc(Q);
      if (i == 7) chk(sda_line == e[7], "R8 D7 before first rise", sda_line, e[7]);
      m_scl = 1'b1; hc(Q/2); got[i] = sda_line; hc(Q/2); m_scl = 1'b0; hc(2);
    end
    chk(got == e, "R8 read byte", got, e);
    m_sda = mack; hc(Q); m_scl = 1'b1; hc(Q); m_scl = 1'b0; hc(6);
    chk(req_n_o == 1'b1, "R9 request cleared after ninth clock", req_n_o, 1);
    bus_stop();
  endtask

  task automatic load_out(input logic [7:0] v);
    out_data_i = v; out_we_i = 1'b1; hc(1); out_we_i = 1'b0; hc(1);
    chk(req_n_o == 1'b0, "R2 request low after load", req_n_o, 0);
  endtask

  task automatic take_in();
    in_taken_i = 1'b1; hc(1); in_taken_i = 1'b0; hc(1);
  endtask

  task automatic set_ctl(input logic [6:0] a, input logic c);
    ctl_addr_i = a; ctl_chk_i = c; ctl_we_i = 1'b1; hc(1); ctl_we_i = 1'b0; hc(1);
  endtask

  initial begin
    hc(5);
    rst = 1'b0;
    hc(1);
    chk(req_n_o == 1'b1, "R1 reset request", req_n_o, 1);
    chk(sda_pull_o == 1'b0, "R1 reset pull", sda_pull_o, 0);
    chk(in_valid_o == 1'b0, "R1 reset strobe", in_valid_o, 0);

    load_out(8'hA5);
    write_txn(7'h2A, 8'h3C, 1'b0, 1'b0, "R3 R6 matched write");
    write_txn(7'h2A, 8'h55, 1'b0, 1'b1, "R7 full inbound");
    chk(in_data_o == 8'h3C, "R7 inbound unchanged", in_data_o, 8'h3C);
    take_in();
    write_txn(7'h2A, 8'h81, 1'b0, 1'b0, "R6 after consume");
    take_in();
    write_txn(7'h11, 8'h77, 1'b1, 1'b1, "R4 mismatch");
    chk(sda_pull_o == 1'b0, "R4 line released", sda_pull_o, 0);
    set_ctl(7'h2A, 1'b0);
    write_txn(7'h11, 8'h99, 1'b0, 1'b0, "R5 check off");
    take_in();
    set_ctl(7'h5B, 1'b1);
    read_txn(7'h5B, 8'hA5, 1'b1);
    load_out(8'h6E);
    read_txn(7'h5B, 8'h6E, 1'b0);

    // R10: abort mid-address, then a full transaction
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    hc(4);
    chk(sda_pull_o == 1'b0, "R10 released after stop", sda_pull_o, 0);
    write_txn(7'h5B, 8'hC3, 1'b0, 1'b0, "R10 after abort");
    take_in();
    hc(10);
    chk(exp_q.size() == 0, "R6 all expected strobes seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule